// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block generates the pixel and line timing of an interlaced standard-definition raster. Each cycle in which the pixel-rate enable is high, it moves forward by one sample position. Two rasters are available: one of 525 lines, used by NTSC and by the PAL-M variant, and one of 625 lines, used by the other PAL variants. A second select picks between rectangular (studio) sampling and square-pixel sampling. Together the two selects fix the number of samples in each line and the width of the active window.

Downstream logic gets a horizontal-active flag, a vertical-active flag, a combined blank, an odd/even field flag, horizontal and vertical sync pulses, and the current pixel and line numbers. A third select shifts the reported line number down by three, which is the line numbering PAL-M uses. The active-line windows are not affected by this shift. Changes to any select wait for the next frame boundary. An analog front end or a clock-recovery loop upstream supplies the enable; both are outside this block.

Top module: `rv_raster_gen`

## Requirements
- R1: While `rst` is high, every output is zero except `blank`, which is one.
- R2: `pix_num` counts from 0 to T-1 and then returns to 0. It advances only in cycles with `pix_en` high. T is 858 for the 525-line raster with rectangular sampling (`std_sel`=0, `sq_sel`=0), 780 for 525/square, 864 for 625/rectangular and 944 for 625/square. These are the parameter defaults.
- R3: `h_act` is high for A consecutive pixels and ends H_FRONT pixels before the end of the line, so the first active pixel is T-A-H_FRONT. A is 720 for both rectangular modes, 640 for 525/square and 768 for 625/square.
- R4: The line count runs from 1 to 525 when `std_sel`=0 and from 1 to 625 when `std_sel`=1. `v_act` is high on lines 23–262 and 285–524 of the 525-line raster, which gives 240 lines per field and 480 per frame. It is high on lines 23–310 and 336–623 of the 625-line raster, which gives 288 per field and 576 per frame.
- R5: `blank` is high exactly when `h_act` or `v_act` is low.
- R6: `field` is 0 from line 1 and becomes 1 at pixel 0 of line 263 (525-line raster) or line 313 (625-line raster). It stays 1 until the frame wraps.
- R7: With `std_sel`=0 and `mnum_sel`=1, `line_num` reports the internal count minus 3, and counts 1–3 are reported as 523–525. With `std_sel`=1, `mnum_sel` is ignored.
- R8: `hsync` is high for pixels 0 to HSYNC_W-1 of every line. `vsync` is high for the first VSYNC_L lines of each field.
- R9: The selects are captured while `rst` is high and at the wrap from the last pixel of a frame to the first. A change in the middle of a frame does not alter the current frame.
- R10: All outputs are registered. They update only in the cycle after a `pix_en` cycle, all from the same counter position, and they hold while `pix_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-rate enable |
| std_sel | input | 1 | 0: 525-line raster, 1: 625-line raster |
| sq_sel | input | 1 | 0: rectangular sampling, 1: square sampling |
| mnum_sel | input | 1 | 1: line numbers shifted by 3 (525-line raster only) |
| pix_num | output | PIX_W | Current pixel number |
| line_num | output | 10 | Current reported line number |
| h_act | output | 1 | Horizontal active window |
| v_act | output | 1 | Vertical active window |
| blank | output | 1 | High outside the active picture |
| field | output | 1 | 0 in the odd field, 1 in the even field |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |

## Verification
Two events can fall on the same edge: a select change that arrives in the middle of a frame, and the frame wrap that finally applies it. The bench switches the sampling select about a thousand pixels into a frame. It then confirms that the rest of that frame still reaches the old line length. It also confirms that the next frame starts at pixel 0 of line 1 and runs with the new length. The field flag changes on the same edge as a line wrap, so the bench records the reported line number at the rising edge of `field` and checks it for each standard, including the shifted numbering.

// File: rtl/rv_pkg.sv
package rv_pkg;
  localparam int LINE_W = 10;
  localparam int LINES_525 = 525;
  localparam int LINES_625 = 625;
  localparam int M_SHIFT = 3;

  // active windows and second-field start per raster
  localparam int A525_O_FIRST = 23;
  localparam int A525_O_LAST  = 262;
  localparam int A525_E_FIRST = 285;
  localparam int A525_E_LAST  = 524;
  localparam int A625_O_FIRST = 23;
  localparam int A625_O_LAST  = 310;
  localparam int A625_E_FIRST = 336;
  localparam int A625_E_LAST  = 623;
  localparam int F2_525 = 263;
  localparam int F2_625 = 313;

  typedef struct packed {
    logic pal;   // 625-line raster
    logic sq;    // square sampling
    logic mnum;  // shifted line numbering
  } rv_cfg_t;

  function automatic logic [LINE_W-1:0] report_line(input logic [LINE_W-1:0] cnt,
                                                    input logic shift);
    if (!shift) return cnt;
    if (cnt > LINE_W'(M_SHIFT)) return cnt - LINE_W'(M_SHIFT);
    return cnt + LINE_W'(LINES_525 - M_SHIFT);
  endfunction
endpackage

// File: rtl/rv_cfg_sel.sv
module rv_cfg_sel import rv_pkg::*; #(
  parameter int PIX_W       = 10,
  parameter int N_RECT_TOT  = 858,
  parameter int N_RECT_ACT  = 720,
  parameter int N_SQ_TOT    = 780,
  parameter int N_SQ_ACT    = 640,
  parameter int P_RECT_TOT  = 864,
  parameter int P_RECT_ACT  = 720,
  parameter int P_SQ_TOT    = 944,
  parameter int P_SQ_ACT    = 768
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             std_sel,
  input  logic             sq_sel,
  input  logic             mnum_sel,
  output rv_cfg_t          cfg_q,
  output logic [PIX_W-1:0] h_tot,
  output logic [PIX_W-1:0] h_len
);
  always_ff @(posedge clk) begin
    if (rst || load) begin
      cfg_q.pal  <= std_sel;
      cfg_q.sq   <= sq_sel;
      cfg_q.mnum <= mnum_sel & ~std_sel;
    end
  end

  always_comb begin
    unique case ({cfg_q.pal, cfg_q.sq})
      2'b00:   begin h_tot = PIX_W'(N_RECT_TOT); h_len = PIX_W'(N_RECT_ACT); end
      2'b01:   begin h_tot = PIX_W'(N_SQ_TOT);   h_len = PIX_W'(N_SQ_ACT);   end
      2'b10:   begin h_tot = PIX_W'(P_RECT_TOT); h_len = PIX_W'(P_RECT_ACT); end
      default: begin h_tot = PIX_W'(P_SQ_TOT);   h_len = PIX_W'(P_SQ_ACT);   end
    endcase
  end
endmodule

// File: rtl/rv_hcount.sv
module rv_hcount #(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PIX_W-1:0] h_tot,
  output logic [PIX_W-1:0] pix,
  output logic             last
);
  assign last = (pix == h_tot - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)     pix <= '0;
    else if (en) pix <= last ? '0 : pix + 1'b1;
  end
endmodule

// File: rtl/rv_vcount.sv
module rv_vcount import rv_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pal,
  output logic [LINE_W-1:0] line,
  output logic              last
);
  assign last = (line == (pal ? LINE_W'(LINES_625) : LINE_W'(LINES_525)));

  always_ff @(posedge clk) begin
    if (rst)     line <= LINE_W'(1);
    else if (en) line <= last ? LINE_W'(1) : line + 1'b1;
  end
endmodule

// File: rtl/rv_raster_gen.sv
module rv_raster_gen import rv_pkg::*; #(
  parameter int N_RECT_TOT = 858,
  parameter int N_RECT_ACT = 720,
  parameter int N_SQ_TOT   = 780,
  parameter int N_SQ_ACT   = 640,
  parameter int P_RECT_TOT = 864,
  parameter int P_RECT_ACT = 720,
  parameter int P_SQ_TOT   = 944,
  parameter int P_SQ_ACT   = 768,
  parameter int H_FRONT    = 16,
  parameter int HSYNC_W    = 64,
  parameter int VSYNC_L    = 3,
  localparam int MAX_N     = (N_RECT_TOT > N_SQ_TOT) ? N_RECT_TOT : N_SQ_TOT,
  localparam int MAX_P     = (P_RECT_TOT > P_SQ_TOT) ? P_RECT_TOT : P_SQ_TOT,
  localparam int PIX_W     = $clog2(((MAX_N > MAX_P) ? MAX_N : MAX_P) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic              std_sel,
  input  logic              sq_sel,
  input  logic              mnum_sel,
  output logic [PIX_W-1:0]  pix_num,
  output logic [LINE_W-1:0] line_num,
  output logic              h_act,
  output logic              v_act,
  output logic              blank,
  output logic              field,
  output logic              hsync,
  output logic              vsync
);
  rv_cfg_t           cfg_q;
  logic [PIX_W-1:0]  h_tot, h_len, pix_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              h_last, v_last, frame_wrap;

  assign frame_wrap = pix_en && h_last && v_last;

  rv_cfg_sel #(
    .PIX_W(PIX_W),
    .N_RECT_TOT(N_RECT_TOT), .N_RECT_ACT(N_RECT_ACT),
    .N_SQ_TOT(N_SQ_TOT),     .N_SQ_ACT(N_SQ_ACT),
    .P_RECT_TOT(P_RECT_TOT), .P_RECT_ACT(P_RECT_ACT),
    .P_SQ_TOT(P_SQ_TOT),     .P_SQ_ACT(P_SQ_ACT)
  ) cfg_i (
    .clk(clk), .rst(rst), .load(frame_wrap),
    .std_sel(std_sel), .sq_sel(sq_sel), .mnum_sel(mnum_sel),
    .cfg_q(cfg_q), .h_tot(h_tot), .h_len(h_len)
  );

  rv_hcount #(.PIX_W(PIX_W)) hcnt_i (
    .clk(clk), .rst(rst), .en(pix_en), .h_tot(h_tot),
    .pix(pix_cnt), .last(h_last)
  );

  rv_vcount vcnt_i (
    .clk(clk), .rst(rst), .en(pix_en && h_last), .pal(cfg_q.pal),
    .line(line_cnt), .last(v_last)
  );

  // combinational decode of the current counter position
  logic [PIX_W-1:0]  h_start, h_end;
  logic [LINE_W-1:0] f2_line;
  logic              ha_d, va_d, fld_d, hs_d, vs_d;

  always_comb begin
    h_end   = h_tot - PIX_W'(H_FRONT);
    h_start = h_end - h_len;
    ha_d    = (pix_cnt >= h_start) && (pix_cnt < h_end);
    if (cfg_q.pal) begin
      va_d    = ((line_cnt >= LINE_W'(A625_O_FIRST)) && (line_cnt <= LINE_W'(A625_O_LAST))) ||
                ((line_cnt >= LINE_W'(A625_E_FIRST)) && (line_cnt <= LINE_W'(A625_E_LAST)));
      f2_line = LINE_W'(F2_625);
    end else begin
      va_d    = ((line_cnt >= LINE_W'(A525_O_FIRST)) && (line_cnt <= LINE_W'(A525_O_LAST))) ||
                ((line_cnt >= LINE_W'(A525_E_FIRST)) && (line_cnt <= LINE_W'(A525_E_LAST)));
      f2_line = LINE_W'(F2_525);
    end
    fld_d = (line_cnt >= f2_line);
    hs_d  = (pix_cnt < PIX_W'(HSYNC_W));
    vs_d  = (line_cnt < LINE_W'(1 + VSYNC_L)) ||
            ((line_cnt >= f2_line) && (line_cnt < f2_line + LINE_W'(VSYNC_L)));
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_num  <= '0;
      line_num <= '0;
      h_act    <= 1'b0;
      v_act    <= 1'b0;
      blank    <= 1'b1;
      field    <= 1'b0;
      hsync    <= 1'b0;
      vsync    <= 1'b0;
    end else if (pix_en) begin
      pix_num  <= pix_cnt;
      line_num <= report_line(line_cnt, cfg_q.mnum);
      h_act    <= ha_d;
      v_act    <= va_d;
      blank    <= ~(ha_d & va_d);
      field    <= fld_d;
      hsync    <= hs_d;
      vsync    <= vs_d;
    end
  end
endmodule

// File: rtl/rv_raster_chk.sv
module rv_raster_chk #(
  parameter int PIX_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_en,
  input logic [PIX_W-1:0] pix_num,
  input logic [9:0]       line_num,
  input logic             field,
  input logic [2:0]       cfg_q,
  input logic [PIX_W-1:0] pix_cnt,
  input logic [9:0]       line_cnt
);
  // R2: the reported pixel steps by one or returns to zero
  a_r2_pix_step: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> ((pix_num == $past(pix_num) + 1'b1) || (pix_num == '0)));

  // R10: outputs hold while the enable is low
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(pix_num) && $stable(line_num) && $stable(field)));

  // R6: the field flag rises only at the start of a line
  a_r6_field_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(field) |-> (pix_num == '0));

  // R6: the field flag falls only at the start of a line
  a_r6_field_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(field) |-> (pix_num == '0));

  // R9: the captured selects change only when the counters sit at frame start
  a_r9_cfg_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> ((pix_cnt == '0) && (line_cnt == 10'd1)));
endmodule

bind rv_raster_gen rv_raster_chk #(.PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst(rst), .pix_en(pix_en), .pix_num(pix_num),
  .line_num(line_num), .field(field), .cfg_q(cfg_q),
  .pix_cnt(pix_cnt), .line_cnt(line_cnt)
);

// File: tb/rv_raster_gen_tb_top.sv
module rv_raster_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic std_sel = 1'b0, sq_sel = 1'b0, mnum_sel = 1'b0;

  always #5 clk = ~clk;

  // reduced line lengths for whole-frame runs
  localparam int NRT = 30, NRA = 20, NST = 28, NSA = 16;
  localparam int PRT = 32, PRA = 20, PST = 36, PSA = 24;
  localparam int FP = 2, HW = 3, VL = 3;

  logic [5:0] pix_num;
  logic [9:0] line_num;
  logic h_act, v_act, blank, field, hsync, vsync;

  rv_raster_gen #(
    .N_RECT_TOT(NRT), .N_RECT_ACT(NRA), .N_SQ_TOT(NST), .N_SQ_ACT(NSA),
    .P_RECT_TOT(PRT), .P_RECT_ACT(PRA), .P_SQ_TOT(PST), .P_SQ_ACT(PSA),
    .H_FRONT(FP), .HSYNC_W(HW), .VSYNC_L(VL)
  ) dut_i (
    .clk(clk), .rst(rst), .pix_en(pix_en), .std_sel(std_sel), .sq_sel(sq_sel),
    .mnum_sel(mnum_sel), .pix_num(pix_num), .line_num(line_num), .h_act(h_act),
    .v_act(v_act), .blank(blank), .field(field), .hsync(hsync), .vsync(vsync)
  );

  // full-size instance with default parameters
  logic [9:0] b_pix, b_line;
  logic b_ha, b_va, b_bl, b_fld, b_hs, b_vs;

  rv_raster_gen big_i (
    .clk(clk), .rst(rst), .pix_en(pix_en), .std_sel(std_sel), .sq_sel(sq_sel),
    .mnum_sel(mnum_sel), .pix_num(b_pix), .line_num(b_line), .h_act(b_ha),
    .v_act(b_va), .blank(b_bl), .field(b_fld), .hsync(b_hs), .vsync(b_vs)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // statistics gathered by scan
  int ap[2], al[2], maxp, maxl, minl_act, rise_line, minhp, blank_err, hs_n, vs_n;
  int first_pix, first_line;

  task automatic do_reset(input logic s, input logic q, input logic m);
    @(negedge clk);
    rst = 1'b1; pix_en = 1'b0;
    std_sel = s; sq_sel = q; mnum_sel = m;
    repeat (3) @(negedge clk);
    rst = 1'b0; pix_en = 1'b1;
  endtask

  task automatic scan(input int n);
    logic prev_f;
    ap = '{0, 0}; al = '{0, 0};
    maxp = 0; maxl = 0; minl_act = 9999; rise_line = -1; minhp = 9999;
    blank_err = 0; hs_n = 0; vs_n = 0;
    prev_f = field;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin first_pix = int'(pix_num); first_line = int'(line_num); end
      if (h_act && v_act) ap[field]++;
      if (v_act && pix_num == 0) al[field]++;
      if (int'(pix_num) > maxp) maxp = int'(pix_num);
      if (int'(line_num) > maxl) maxl = int'(line_num);
      if (v_act && int'(line_num) < minl_act) minl_act = int'(line_num);
      if (h_act && int'(pix_num) < minhp) minhp = int'(pix_num);
      if (blank != !(h_act && v_act)) blank_err++;
      if (hsync) hs_n++;
      if (vsync) vs_n++;
      if (field && !prev_f) rise_line = int'(line_num);
      prev_f = field;
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1; pix_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pix_num", int'(pix_num), 0);
    chk("R1 line_num", int'(line_num), 0);
    chk("R1 blank", int'(blank), 1);
    chk("R1 flags", int'({h_act, v_act, field, hsync, vsync}), 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rst = 1'b1; pix_en = 1'b0; std_sel = 0; sq_sel = 0; mnum_sel = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 idle blank", int'(blank), 1);
    chk("R10 idle line", int'(line_num), 0);
    pix_en = 1'b1; @(negedge clk); pix_en = 1'b0;
    chk("R10 first pix", int'(pix_num), 0);
    chk("R10 first line", int'(line_num), 1);
    pix_en = 1'b1; @(negedge clk); pix_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 held pix", int'(pix_num), 1);
  endtask

  task automatic t_mode(input string nm, input logic s, input logic q, input logic m,
                        input int tot, input int act, input int lines, input int vpf,
                        input int rise_exp, input int first_exp);
    do_reset(s, q, m);
    scan(lines * tot);
    $display("mode %s", nm);
    chk("R2 max pix", maxp, tot - 1);
    chk("R3 first active pix", minhp, tot - act - FP);
    chk("R3 R4 odd active pixels", ap[0], vpf * act);
    chk("R3 R4 even active pixels", ap[1], vpf * act);
    chk("R4 odd active lines", al[0], vpf);
    chk("R4 even active lines", al[1], vpf);
    chk("R4 max line", maxl, lines);
    chk("R5 blank mismatches", blank_err, 0);
    chk("R6 field rise line", rise_line, rise_exp);
    chk("R7 first active line", minl_act, first_exp);
    chk("R8 hsync samples", hs_n, lines * HW);
    chk("R8 vsync samples", vs_n, 2 * VL * tot);
  endtask

  task automatic t_switch();
    do_reset(1'b0, 1'b0, 1'b0);
    scan(1000);
    sq_sel = 1'b1;
    scan(525 * NRT - 1000);
    chk("R9 old length kept", maxp, NRT - 1);
    scan(525 * NST);
    chk("R9 new frame pix", first_pix, 0);
    chk("R9 new frame line", first_line, 1);
    chk("R9 new length", maxp, NST - 1);
    chk("R9 new active", ap[0], 240 * NSA);
  endtask

  task automatic t_big(input logic s, input logic q, input int tot, input int act);
    int hn, mp;
    do_reset(s, q, 1'b0);
    hn = 0; mp = 0;
    for (int i = 0; i < tot; i++) begin
      @(negedge clk);
      if (b_ha) hn++;
      if (int'(b_pix) > mp) mp = int'(b_pix);
    end
    chk("R2 default total", mp, tot - 1);
    chk("R3 default active", hn, act);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_stall();
    t_mode("525 rect", 0, 0, 0, NRT, NRA, 525, 240, 263, 23);
    t_mode("525 sq",   0, 1, 0, NST, NSA, 525, 240, 263, 23);
    t_mode("625 rect", 1, 0, 0, PRT, PRA, 625, 288, 313, 23);
    t_mode("625 sq",   1, 1, 0, PST, PSA, 625, 288, 313, 23);
    t_mode("525 shifted", 0, 0, 1, NRT, NRA, 525, 240, 260, 20);
    t_mode("625 shift ignored", 1, 0, 1, PRT, PRA, 625, 288, 313, 23);
    t_switch();
    t_big(0, 0, 858, 720);
    t_big(0, 1, 780, 640);
    t_big(1, 0, 864, 720);
    t_big(1, 1, 944, 768);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule